// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the processor-side half of interrupt handling. It keeps the condition code fields that govern acceptance: a 2-bit current priority level and a global interrupt enable bit. It watches the highest pending request that the interrupt controller presents. At each instruction boundary it decides whether the request may preempt the running code. A request is taken only when it is strictly more urgent than the current level (a lower value) and interrupts are enabled globally.

Once a request is taken, the block runs a fixed sequence. It pushes the return address and then the program status word onto a stack that grows downward. It then reads the handler address from a vector table, raises the current level to the level it accepted, and issues a jump. Only a request that is more urgent still can nest inside the handler. A return request at an instruction boundary undoes the entry. It pops the status word first and then the return address, restores the level, the enable bit and the remaining status bits, and jumps back.

The stack and the vector table sit behind simple request/ready ports. A request stays asserted, with its address and data held, until the memory answers.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is accepted only if its level is numerically lower than `ccr_level`. A level-3 request is therefore never accepted.
- R2: A request is accepted only while `ccr_ie` is 1.
- R3: Acceptance and return start only on a cycle where `insn_boundary` is high while the block is idle. Requests at any other time have no effect.
- R4: Entry writes the PC at address SP-2 and then the status word at SP-4, and SP drops by 2 on each completed write. Status word layout: bits [1:0] are the level, bit [2] is the enable bit, and the upper bits are `ps_ext_in`. The level and enable bits are the values held at acceptance.
- R5: After both writes complete, the vector table is read at `VEC_BASE - 2*irq_src`, using the source index captured at acceptance.
- R6: When the vector read completes, `ccr_level` takes the accepted level. `ccr_ie` is left unchanged.
- R7: In the cycle after the vector arrives, `pc_load` is high for exactly one cycle, with `pc_value` equal to the word that was read. The block is then idle.
- R8: A boundary with `reti_req` high starts a return, and this takes priority over a pending request. The return reads the status word at SP, then the PC at SP+2, with SP rising by 2 after each read. It restores the level, the enable bit and `ps_ext_out`, then pulses `pc_load` with the restored PC.
- R9: `busy` is high from the cycle after acceptance or return start, through the cycle in which `pc_load` is high, and low at all other times.
- R10: After reset, `ccr_level` is 3, `ccr_ie` is 0, SP is `SP_INIT`, `busy` is 0, and no memory request is active.
- R11: `ccr_wr` loads `ccr_ie` and `ccr_level` only while the block is idle and no sequence starts in that cycle. A write while busy is ignored.
- R12: While `stk_ready` is low, an active stack request keeps its address, write flag and write data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_boundary | input | 1 | Strobe marking an instruction boundary |
| irq_valid | input | 1 | Interrupt controller has a pending request |
| irq_level | input | 2 | Level of the pending request (0 most urgent) |
| irq_src | input | SRC_W | Source index of the pending request |
| reti_req | input | 1 | Return-from-interrupt requested at this boundary |
| pc_in | input | ADDR_W | Address execution would resume at |
| ps_ext_in | input | DATA_W-3 | Status bits beyond the level and enable fields |
| ccr_wr | input | 1 | Instruction write of the enable and level fields |
| ccr_wr_ie | input | 1 | Enable value for `ccr_wr` |
| ccr_wr_level | input | 2 | Level value for `ccr_wr` |
| stk_req | output | 1 | Stack access request |
| stk_we | output | 1 | Stack access is a write |
| stk_addr | output | ADDR_W | Stack byte address |
| stk_wdata | output | DATA_W | Stack write data |
| stk_rdata | input | DATA_W | Stack read data, valid with `stk_ready` |
| stk_ready | input | 1 | Stack access completes this cycle |
| vec_req | output | 1 | Vector table read request |
| vec_addr | output | ADDR_W | Vector entry byte address |
| vec_rdata | input | DATA_W | Handler address, valid with `vec_ready` |
| vec_ready | input | 1 | Vector read completes this cycle |
| busy | output | 1 | Entry or return sequence in progress |
| pc_load | output | 1 | One-cycle jump strobe |
| pc_value | output | ADDR_W | Jump target |
| ccr_ie | output | 1 | Global interrupt enable |
| ccr_level | output | 2 | Current priority level |
| ps_ext_out | output | DATA_W-3 | Upper status bits restored by the last return |
| sp_out | output | ADDR_W | Stack pointer |

## Verification
The assertions assume that the memory ports answer in finite time. They also assume that `stk_rdata` and `vec_rdata` are meaningful only in a cycle where the matching ready signal is high. They make no assumption about how often the boundary strobe arrives, or how it is timed against requests and returns. The stimulus raises both ready signals with random gaps, so sequences are stretched by wait states. It drives the boundary, request, return and register-write inputs freely in every cycle, including while a sequence is running. Memory read data always comes from a stack image that the bench keeps itself, and from a fixed function of the vector address.

// File: rtl/irq_seq_pkg.sv
// Shared types for the interrupt entry/return sequencer.
// Assumes a 2-bit level encoding where 0 is most urgent and 3 masks all.
package irq_seq_pkg;
    localparam int LVL_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_PC = 3'd1,
        ST_PUSH_PS = 3'd2,
        ST_VEC     = 3'd3,
        ST_JUMP    = 3'd4,
        ST_POP_PS  = 3'd5,
        ST_POP_PC  = 3'd6
    } seq_state_t;

    typedef struct packed {
        logic             ie;
        logic [LVL_W-1:0] lvl;
    } ccr_t;
endpackage

// File: rtl/irq_gate.sv
// Acceptance decision: starts a return or an entry at an instruction boundary.
// Assumes the caller only cares about the outputs while the sequencer is idle.
module irq_gate
    import irq_seq_pkg::*;
(
    input  logic             idle,
    input  logic             insn_boundary,
    input  logic             reti_req,
    input  logic             irq_valid,
    input  logic [LVL_W-1:0] irq_level,
    input  ccr_t             ccr,
    output logic             start_entry,
    output logic             start_return
);
    logic at_boundary;
    logic more_urgent;

    // Decide which sequence, if any, begins this cycle; return wins.
    always_comb begin
        at_boundary  = idle && insn_boundary;
        more_urgent  = irq_level < ccr.lvl;
        start_return = at_boundary && reti_req;
        start_entry  = at_boundary && !reti_req && irq_valid && ccr.ie && more_urgent;
    end
endmodule

// File: rtl/irq_ccr.sv
// Holds the enable bit, the current level and the restored upper status bits.
// Assumes at most one of restore / lvl_load / wr is meaningful per cycle;
// restore takes precedence, then level load, then instruction write.
module irq_ccr
    import irq_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              wr_ie,
    input  logic [LVL_W-1:0]  wr_lvl,
    input  logic              lvl_load,
    input  logic [LVL_W-1:0]  lvl_new,
    input  logic              restore,
    input  logic [DATA_W-1:0] restore_word,
    output ccr_t              ccr,
    output logic [DATA_W-4:0] ps_ext
);
    // Update the condition code fields from the active source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccr.ie  <= 1'b0;
            ccr.lvl <= 2'd3;
            ps_ext  <= '0;
        end else if (restore) begin
            ccr.ie  <= restore_word[2];
            ccr.lvl <= restore_word[1:0];
            ps_ext  <= restore_word[DATA_W-1:3];
        end else if (lvl_load) begin
            ccr.lvl <= lvl_new;
        end else if (wr) begin
            ccr.ie  <= wr_ie;
            ccr.lvl <= wr_lvl;
        end
    end

    // R11
    ccr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore && !lvl_load && !wr) |=> $stable(ccr));
endmodule

// File: rtl/irq_sp.sv
// Downward-growing stack pointer, moved by one word per completed access.
// Assumes dec and inc are never high together.
module irq_sp #(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] SP_INIT = 16'h0800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec,
    input  logic              inc,
    output logic [ADDR_W-1:0] sp
);
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(2);

    // Step the pointer after each completed push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= SP_INIT;
        else if (dec) sp <= sp - WORD_BYTES;
        else if (inc) sp <= sp + WORD_BYTES;
    end

    // R4
    sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec || inc) |=> (sp == $past(sp) - WORD_BYTES) || (sp == $past(sp) + WORD_BYTES));
endmodule

// File: rtl/irq_seq_fsm.sv
// Entry and return sequencer: drives the stack and vector ports and the jump strobe.
// Assumes ADDR_W <= DATA_W so a PC fits one stack word, and that read data
// is only meaningful in the cycle its ready signal is high.
module irq_seq_fsm
    import irq_seq_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 16,
    parameter int                SRC_W    = 3,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_entry,
    input  logic              start_return,
    input  logic [LVL_W-1:0]  acc_level,
    input  logic [SRC_W-1:0]  acc_src,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] ps_word_in,
    input  logic [ADDR_W-1:0] sp,
    input  logic              stk_ready,
    input  logic [DATA_W-1:0] stk_rdata,
    input  logic              vec_ready,
    input  logic [DATA_W-1:0] vec_rdata,
    output logic              idle,
    output logic              busy,
    output logic              stk_req,
    output logic              stk_we,
    output logic [ADDR_W-1:0] stk_addr,
    output logic [DATA_W-1:0] stk_wdata,
    output logic              vec_req,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              sp_dec,
    output logic              sp_inc,
    output logic              lvl_load,
    output logic [LVL_W-1:0]  lvl_new,
    output logic              restore,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_value
);
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(2);

    seq_state_t        st;
    logic [ADDR_W-1:0] pc_hold;
    logic [DATA_W-1:0] psw_hold;
    logic [LVL_W-1:0]  lvl_hold;
    logic [SRC_W-1:0]  src_hold;
    logic              pushing;
    logic              popping;

    // Advance the sequence and capture the context it works on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            pc_hold  <= '0;
            psw_hold <= '0;
            lvl_hold <= 2'd3;
            src_hold <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start_return) begin
                        st <= ST_POP_PS;
                    end else if (start_entry) begin
                        st       <= ST_PUSH_PC;
                        pc_hold  <= pc_in;
                        psw_hold <= ps_word_in;
                        lvl_hold <= acc_level;
                        src_hold <= acc_src;
                    end
                end
                ST_PUSH_PC: if (stk_ready) st <= ST_PUSH_PS;
                ST_PUSH_PS: if (stk_ready) st <= ST_VEC;
                ST_VEC: begin
                    if (vec_ready) begin
                        pc_hold <= ADDR_W'(vec_rdata);
                        st      <= ST_JUMP;
                    end
                end
                ST_JUMP:   st <= ST_IDLE;
                ST_POP_PS: if (stk_ready) st <= ST_POP_PC;
                ST_POP_PC: begin
                    if (stk_ready) begin
                        pc_hold <= ADDR_W'(stk_rdata);
                        st      <= ST_JUMP;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Decode the port drives and the side-effect strobes from the state.
    always_comb begin
        pushing   = (st == ST_PUSH_PC) || (st == ST_PUSH_PS);
        popping   = (st == ST_POP_PS) || (st == ST_POP_PC);
        idle      = (st == ST_IDLE);
        busy      = !idle;
        stk_req   = pushing || popping;
        stk_we    = pushing;
        stk_addr  = pushing ? (sp - WORD_BYTES) : sp;
        stk_wdata = (st == ST_PUSH_PC) ? DATA_W'(pc_hold) : psw_hold;
        sp_dec    = pushing && stk_ready;
        sp_inc    = popping && stk_ready;
        vec_req   = (st == ST_VEC);
        vec_addr  = VEC_BASE - (ADDR_W'(src_hold) << 1);
        lvl_load  = (st == ST_VEC) && vec_ready;
        lvl_new   = lvl_hold;
        restore   = (st == ST_POP_PS) && stk_ready;
        pc_load   = (st == ST_JUMP);
        pc_value  = pc_hold;
    end

    // R12
    stk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_req && !stk_ready) |=> stk_req && $stable(stk_addr) && $stable(stk_we) && $stable(stk_wdata));

    // R5
    vec_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_req) |-> $past(stk_req && stk_we && stk_ready));

    // R7
    jump_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load && !busy);
endmodule

// File: rtl/irq_entry_seq.sv
// Top of the interrupt entry/return sequencer: acceptance gate, condition
// code fields, stack pointer and sequence controller.
// Assumes the controller presents its most urgent request on irq_level/irq_src.
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 16,
    parameter int                SRC_W    = 3,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFFE,
    parameter logic [ADDR_W-1:0] SP_INIT  = 16'h0800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_boundary,
    input  logic              irq_valid,
    input  logic [1:0]        irq_level,
    input  logic [SRC_W-1:0]  irq_src,
    input  logic              reti_req,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-4:0] ps_ext_in,
    input  logic              ccr_wr,
    input  logic              ccr_wr_ie,
    input  logic [1:0]        ccr_wr_level,
    output logic              stk_req,
    output logic              stk_we,
    output logic [ADDR_W-1:0] stk_addr,
    output logic [DATA_W-1:0] stk_wdata,
    input  logic [DATA_W-1:0] stk_rdata,
    input  logic              stk_ready,
    output logic              vec_req,
    output logic [ADDR_W-1:0] vec_addr,
    input  logic [DATA_W-1:0] vec_rdata,
    input  logic              vec_ready,
    output logic              busy,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_value,
    output logic              ccr_ie,
    output logic [1:0]        ccr_level,
    output logic [DATA_W-4:0] ps_ext_out,
    output logic [ADDR_W-1:0] sp_out
);
    ccr_t              ccr;
    logic              idle;
    logic              start_entry;
    logic              start_return;
    logic              sp_dec;
    logic              sp_inc;
    logic              lvl_load;
    logic [LVL_W-1:0]  lvl_new;
    logic              restore;
    logic              ccr_write_ok;
    logic [DATA_W-1:0] ps_word;

    // Form the saved status word and gate instruction writes to idle cycles.
    always_comb begin
        ps_word      = {ps_ext_in, ccr.ie, ccr.lvl};
        ccr_write_ok = ccr_wr && idle && !start_entry && !start_return;
        ccr_ie       = ccr.ie;
        ccr_level    = ccr.lvl;
    end

    irq_gate u_gate (
        .idle          (idle),
        .insn_boundary (insn_boundary),
        .reti_req      (reti_req),
        .irq_valid     (irq_valid),
        .irq_level     (irq_level),
        .ccr           (ccr),
        .start_entry   (start_entry),
        .start_return  (start_return)
    );

    irq_ccr #(.DATA_W(DATA_W)) u_ccr (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (ccr_write_ok),
        .wr_ie        (ccr_wr_ie),
        .wr_lvl       (ccr_wr_level),
        .lvl_load     (lvl_load),
        .lvl_new      (lvl_new),
        .restore      (restore),
        .restore_word (stk_rdata),
        .ccr          (ccr),
        .ps_ext       (ps_ext_out)
    );

    irq_sp #(.ADDR_W(ADDR_W), .SP_INIT(SP_INIT)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (sp_dec),
        .inc   (sp_inc),
        .sp    (sp_out)
    );

    irq_seq_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SRC_W    (SRC_W),
        .VEC_BASE (VEC_BASE)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_entry  (start_entry),
        .start_return (start_return),
        .acc_level    (irq_level),
        .acc_src      (irq_src),
        .pc_in        (pc_in),
        .ps_word_in   (ps_word),
        .sp           (sp_out),
        .stk_ready    (stk_ready),
        .stk_rdata    (stk_rdata),
        .vec_ready    (vec_ready),
        .vec_rdata    (vec_rdata),
        .idle         (idle),
        .busy         (busy),
        .stk_req      (stk_req),
        .stk_we       (stk_we),
        .stk_addr     (stk_addr),
        .stk_wdata    (stk_wdata),
        .vec_req      (vec_req),
        .vec_addr     (vec_addr),
        .sp_dec       (sp_dec),
        .sp_inc       (sp_inc),
        .lvl_load     (lvl_load),
        .lvl_new      (lvl_new),
        .restore      (restore),
        .pc_load      (pc_load),
        .pc_value     (pc_value)
    );

    // R1
    level_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && insn_boundary && !reti_req && (irq_level >= ccr_level)) |=> !busy);

    // R2
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && insn_boundary && !reti_req && !ccr_ie) |=> !busy);

    // R3
    boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !insn_boundary) |=> !busy);

    // R9
    busy_ends_with_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(pc_load));

    // R9
    jump_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load || stk_req || vec_req) |-> busy);
endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
    localparam int          AW   = 16;
    localparam int          DW   = 16;
    localparam int          SW   = 3;
    localparam logic [15:0] VBASE = 16'hFFFE;
    localparam logic [15:0] SPI   = 16'h0800;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          insn_boundary = 1'b0, irq_valid = 1'b0, reti_req = 1'b0;
    logic [1:0]    irq_level = 2'd3;
    logic [SW-1:0] irq_src = '0;
    logic [AW-1:0] pc_in = '0;
    logic [DW-4:0] ps_ext_in = '0;
    logic          ccr_wr = 1'b0, ccr_wr_ie = 1'b0;
    logic [1:0]    ccr_wr_level = 2'd0;
    logic          stk_req, stk_we, vec_req, busy, pc_load, ccr_ie;
    logic [AW-1:0] stk_addr, vec_addr, pc_value, sp_out;
    logic [DW-1:0] stk_wdata, stk_rdata, vec_rdata;
    logic          stk_ready = 1'b1, vec_ready = 1'b1;
    logic [1:0]    ccr_level;
    logic [DW-4:0] ps_ext_out;

    irq_entry_seq uut (.*);

    // Bench memories: stack image and a vector table computed from the address.
    logic [15:0] smem [0:255];
    always_comb stk_rdata = smem[stk_addr[8:1]];
    assign vec_rdata = vec_addr ^ 16'hA5C3;
    always @(posedge clk) if (stk_req && stk_we && stk_ready) smem[stk_addr[8:1]] <= stk_wdata;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;
    logic [15:0] last_jump = '0;
    always @(posedge clk) if (pc_load) last_jump <= pc_value;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Reference model: phase 0 idle, 1/2 pushes, 3 vector, 4 jump, 5/6 pops.
    int          m_ph = 0;
    logic [15:0] m_sp = SPI, m_pc = '0, m_psw = '0, m_vaddr = '0;
    logic        m_ie = 1'b0;
    logic [1:0]  m_lvl = 2'd3, m_new = 2'd3;
    logic [12:0] m_ext = '0;
    always @(posedge clk) begin
        logic [15:0] rd;
        rd = smem[m_sp[8:1]];
        if (!rst_n) begin
            m_ph = 0; m_sp = SPI; m_ie = 1'b0; m_lvl = 2'd3; m_ext = '0;
        end else begin
            case (m_ph)
                0: begin
                    if (insn_boundary && reti_req) m_ph = 5;
                    else if (insn_boundary && irq_valid && m_ie && irq_level < m_lvl) begin
                        m_pc = pc_in; m_psw = {ps_ext_in, m_ie, m_lvl};
                        m_new = irq_level; m_vaddr = VBASE - 16'(2 * irq_src); m_ph = 1;
                    end else if (ccr_wr) begin
                        m_ie = ccr_wr_ie; m_lvl = ccr_wr_level;
                    end
                end
                1: if (stk_ready) begin m_sp = m_sp - 16'd2; m_ph = 2; end
                2: if (stk_ready) begin m_sp = m_sp - 16'd2; m_ph = 3; end
                3: if (vec_ready) begin m_pc = m_vaddr ^ 16'hA5C3; m_lvl = m_new; m_ph = 4; end
                4: m_ph = 0;
                5: if (stk_ready) begin
                    m_ie = rd[2]; m_lvl = rd[1:0]; m_ext = rd[15:3]; m_sp = m_sp + 16'd2; m_ph = 6;
                end
                6: if (stk_ready) begin m_pc = rd; m_sp = m_sp + 16'd2; m_ph = 4; end
                default: m_ph = 0;
            endcase
        end
    end

    // Compare every output against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(busy == (m_ph != 0), "R9 busy", busy, m_ph != 0);
            chk(pc_load == (m_ph == 4), "R7 pc_load", pc_load, m_ph == 4);
            if (m_ph == 4) chk(pc_value == m_pc, "R7/R8 pc_value", pc_value, m_pc);
            chk(stk_req == (m_ph == 1 || m_ph == 2 || m_ph == 5 || m_ph == 6), "R4 stk_req", stk_req, m_ph);
            if (m_ph == 1 || m_ph == 2) begin
                chk(stk_we && stk_addr == m_sp - 16'd2, "R4/R12 push addr", stk_addr, m_sp - 16'd2);
                chk(stk_wdata == ((m_ph == 1) ? m_pc : m_psw), "R4 push data", stk_wdata,
                    (m_ph == 1) ? m_pc : m_psw);
            end
            if (m_ph == 5 || m_ph == 6) chk(!stk_we && stk_addr == m_sp, "R8 pop addr", stk_addr, m_sp);
            chk(vec_req == (m_ph == 3), "R5 vec_req", vec_req, m_ph == 3);
            if (m_ph == 3) chk(vec_addr == m_vaddr, "R5 vec_addr", vec_addr, m_vaddr);
            chk(ccr_level == m_lvl, "R6 ccr_level", ccr_level, m_lvl);
            chk(ccr_ie == m_ie, "R11 ccr_ie", ccr_ie, m_ie);
            chk(ps_ext_out == m_ext, "R8 ps_ext_out", ps_ext_out, m_ext);
            chk(sp_out == m_sp, "R4 sp_out", sp_out, m_sp);
        end
    end

    // Watchdog.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    bit rand_ready = 1'b0;
    always @(negedge clk) if (rand_ready) begin
        stk_ready <= ($urandom % 3) != 0;
        vec_ready <= ($urandom % 3) != 0;
    end

    task automatic boundary();
        insn_boundary = 1'b1;
        @(negedge clk);
        insn_boundary = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    endtask

    function automatic logic [15:0] slot(input logic [15:0] a);
        return smem[a[8:1]];
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) smem[i] = 16'(i * 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(ccr_level == 2'd3 && !ccr_ie, "R10 ccr after reset", {ccr_ie, ccr_level}, 3'b011);
        chk(sp_out == SPI && !busy && !stk_req && !vec_req, "R10 idle after reset", sp_out, SPI);
        rand_ready = 1'b1;

        // R2: enable bit clear blocks an urgent request
        irq_valid = 1'b1; irq_level = 2'd0; irq_src = 3'd1;
        boundary();
        chk(!busy, "R2 disabled request taken", busy, 0);

        // R11: write enable and level while idle
        ccr_wr = 1'b1; ccr_wr_ie = 1'b1; ccr_wr_level = 2'd3;
        @(negedge clk);
        ccr_wr = 1'b0;
        chk(ccr_ie && ccr_level == 2'd3, "R11 idle write", {ccr_ie, ccr_level}, 3'b111);

        // R1: a level-3 request is never taken
        irq_level = 2'd3;
        boundary();
        chk(!busy, "R1 level 3 taken", busy, 0);

        // R3: no boundary, no acceptance
        irq_level = 2'd2; irq_src = 3'd5; pc_in = 16'h1234; ps_ext_in = 13'h0ABC;
        repeat (3) @(negedge clk);
        chk(!busy, "R3 taken without boundary", busy, 0);

        // First entry
        boundary();
        chk(busy, "R9 busy after accept", busy, 1);
        irq_valid = 1'b0;
        wait_idle();
        chk(ccr_level == 2'd2 && ccr_ie, "R6 level after entry", {ccr_ie, ccr_level}, 3'b110);
        chk(last_jump == ((VBASE - 16'd10) ^ 16'hA5C3), "R5 handler address", last_jump,
            (VBASE - 16'd10) ^ 16'hA5C3);
        chk(sp_out == SPI - 16'd4, "R4 sp after entry", sp_out, SPI - 16'd4);
        chk(slot(SPI - 16'd2) == 16'h1234, "R4 saved pc", slot(SPI - 16'd2), 16'h1234);
        chk(slot(SPI - 16'd4) == {13'h0ABC, 1'b1, 2'd3}, "R4 saved status", slot(SPI - 16'd4),
            {13'h0ABC, 1'b1, 2'd3});

        // R1: same level cannot nest
        irq_valid = 1'b1; irq_level = 2'd2;
        boundary();
        chk(!busy, "R1 equal level nested", busy, 0);

        // Nest a more urgent request, then try a write while busy (R11)
        irq_level = 2'd1; irq_src = 3'd2; pc_in = 16'h2222; ps_ext_in = 13'h0111;
        boundary();
        irq_valid = 1'b0;
        ccr_wr = 1'b1; ccr_wr_ie = 1'b0; ccr_wr_level = 2'd0;
        @(negedge clk);
        ccr_wr = 1'b0;
        wait_idle();
        chk(ccr_level == 2'd1 && ccr_ie, "R11 write while busy", {ccr_ie, ccr_level}, 3'b101);

        // R8: two returns unwind the nesting; return beats a pending request
        irq_valid = 1'b1; irq_level = 2'd0;
        reti_req = 1'b1;
        boundary();
        reti_req = 1'b0; irq_valid = 1'b0;
        wait_idle();
        chk(last_jump == 16'h2222 && ccr_level == 2'd2, "R8 first return", last_jump, 16'h2222);
        chk(ps_ext_out == 13'h0111, "R8 restored status bits", ps_ext_out, 13'h0111);
        reti_req = 1'b1;
        boundary();
        reti_req = 1'b0;
        wait_idle();
        chk(last_jump == 16'h1234 && ccr_level == 2'd3 && ccr_ie, "R8 second return", last_jump, 16'h1234);
        chk(sp_out == SPI, "R8 sp restored", sp_out, SPI);

        // Free-running stimulus, checked each cycle against the model
        for (int i = 0; i < 6000; i++) begin
            insn_boundary = ($urandom % 4) == 0;
            irq_valid     = ($urandom % 2) == 0;
            irq_level     = 2'($urandom);
            irq_src       = 3'($urandom);
            reti_req      = ($urandom % 8) == 0;
            ccr_wr        = ($urandom % 20) == 0;
            ccr_wr_ie     = ($urandom % 4) != 0;
            ccr_wr_level  = 2'($urandom);
            pc_in         = 16'($urandom);
            ps_ext_in     = 13'($urandom);
            @(negedge clk);
        end
        insn_boundary = 1'b0; ccr_wr = 1'b0; reti_req = 1'b0; irq_valid = 1'b0;
        wait_idle();
        chk(!busy, "R9 settles idle", busy, 0);
        finish_run();
    end
endmodule